// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit side of a synchronous serial link in which the far end owns the bit clock. Software writes a data word into a one-word holding buffer. The word then moves into a shift register as soon as that register is free. Bits leave on a single data output, least significant bit first, one per cycle of the incoming clock. An optional ninth bit is latched with each write. The bit-shift edge of the incoming clock is selectable, and the master samples on the opposite edge.

The incoming clock is not used as a clock. It passes through a synchronizer into the system clock domain, and edge detection runs there. Two words written back to back are queued: one in the shift register and one in the holding buffer. The buffer-empty flag stays low until the waiting word has moved on. That flag, together with two enables, drives an interrupt output. The output driver is enabled only when the port is set up for synchronous, externally clocked transmission.

Top module: `sync_slave_tx`

## Requirements
- R1: `ser_oe` is high only when `cfg_sync`=1, `cfg_clk_master`=0, `cfg_rx_single`=0, `cfg_rx_cont`=0 and `cfg_port_en`=1. In any other setting nothing is accepted or shifted, and `shift_empty` and `buf_empty` read 1.
- R2: With transmission running (R1 setting plus `cfg_tx_en`=1) and the holding buffer empty, a write pulse captures `wr_data`, and `buf_empty` reads 0 after that clock edge. If the shift register is idle, the word moves into it on the next edge: `shift_empty` drops, `buf_empty` rises, and `ser_out` shows bit 0.
- R3: Bits leave least significant first, and each shift edge of `ext_clk` advances `ser_out` by one bit. The shift edge is the falling edge when `cfg_clk_pol`=0 and the rising edge when it is 1. `ser_out` updates on the third system clock edge that samples the new `ext_clk` level.
- R4: A word written while a character is shifting waits in the holding buffer, and `buf_empty` stays 0. At the shift edge that ends the current character, the waiting word enters the shift register with no idle bit, and `buf_empty` rises.
- R5: In nine-bit mode (`cfg_nine_bit`=1), the level of `ninth_bit_in` at the write edge is sent as the ninth and last bit. Later changes to `ninth_bit_in` do not affect that word. In eight-bit mode, eight bits are sent.
- R6: `shift_empty` is 1 when idle and again after the shift edge that ends a character if no word is waiting. `ser_out` rests at 1 when idle.
- R7: A write is ignored while the holding buffer is full, including the edge on which the buffer hands its word over. A write is also ignored while transmission is not running.
- R8: Clearing `cfg_tx_en` discards the shifting character and the waiting word. On the next edge, `shift_empty`=1 and `buf_empty`=1.
- R9: `tx_irq` = `buf_empty` AND `irq_tx_en` AND `irq_periph_en`.
- R10: After reset, `ser_out`=1, `shift_empty`=1 and `buf_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync | input | 1 | Synchronous mode select |
| cfg_clk_master | input | 1 | 1 = local clock source; 0 = external clock (required for transmit) |
| cfg_rx_single | input | 1 | Single-receive enable; must be 0 to transmit |
| cfg_rx_cont | input | 1 | Continuous-receive enable; must be 0 to transmit |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_tx_en | input | 1 | Transmit enable; 0 flushes the path |
| cfg_nine_bit | input | 1 | 1 = nine-bit characters |
| cfg_clk_pol | input | 1 | 0 = shift on falling edge; 1 = shift on rising edge |
| ninth_bit_in | input | 1 | Ninth bit, latched at each write |
| wr_en | input | 1 | Holding-buffer write strobe |
| wr_data | input | DATA_W | Low data bits of the word |
| irq_tx_en | input | 1 | Transmit interrupt enable |
| irq_periph_en | input | 1 | Peripheral interrupt enable |
| ext_clk | input | 1 | Bit clock from the master |
| ser_out | output | 1 | Serial data |
| ser_oe | output | 1 | Output enable for the data pin |
| shift_empty | output | 1 | Shift register idle |
| buf_empty | output | 1 | Holding buffer free |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The link is driven with single words, with back-to-back pairs and with a third write aimed at a full buffer. These patterns separate direct loading, queued handover and dropped writes. Both clock polarities are run, so a design that shifts on the wrong edge shows shifted or doubled bits. Nine-bit words are sent with the ninth input changed right after the write, which shows whether the bit is latched or read live. Disabling transmission mid-character and switching to a receive setting show whether the path flushes and releases the pin. A behavioural model compares all outputs on every cycle, and a bench-side master reassembles each character.

// File: rtl/sst_pkg.sv
package sst_pkg;
  parameter int unsigned SST_DATA_W = 8;

  typedef enum logic {
    SHIFT_ON_FALL = 1'b0,
    SHIFT_ON_RISE = 1'b1
  } sst_edge_e;

  function automatic int unsigned sst_char_len(input logic nine, input int unsigned data_w);
    return nine ? data_w + 1 : data_w;
  endfunction
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic pol,
  output logic shift_pulse
);
  import sst_pkg::*;

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = ext_clk;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], ext_clk};
    end
  endgenerate

  assign synced = chain_q[STAGES-1];
  always_comb prev_d = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  always_comb begin
    if (sst_edge_e'(pol) == SHIFT_ON_RISE) shift_pulse = synced & ~prev_q;
    else                                   shift_pulse = ~synced & prev_q;
  end
endmodule

// File: rtl/sst_holdbuf.sv
module sst_holdbuf #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ninth_in,
  input  logic              take,
  output logic              hold_valid,
  output logic [WORD_W-1:0] hold_word
);
  logic              valid_d;
  logic              load_en;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    load_en = run & wr_en & ~hold_valid & ~take;
    word_d  = {ninth_in, wr_data};
    if (!run)         valid_d = 1'b0;
    else if (take)    valid_d = 1'b0;
    else if (load_en) valid_d = 1'b1;
    else              valid_d = hold_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_valid <= 1'b0;
    else        hold_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_word <= '0;
    else if (load_en) hold_word <= word_d;
  end

  a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && wr_en && !take && run) |=> $stable(hold_word));
  a_r2_write_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && !hold_valid) |=> hold_valid);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WORD_W = DATA_W + 1,
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              nine,
  input  logic              shift_pulse,
  input  logic              hold_valid,
  input  logic [WORD_W-1:0] hold_word,
  output logic              take,
  output logic              busy,
  output logic              ser_bit
);
  import sst_pkg::*;

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_d;
  logic              done;
  logic              sreg_en;

  always_comb begin
    done    = busy & shift_pulse & (cnt_q == CNT_W'(1));
    take    = run & hold_valid & (~busy | done);
    sreg_d  = sreg_q;
    cnt_d   = cnt_q;
    busy_d  = busy;
    sreg_en = 1'b0;
    if (!run) begin
      sreg_d  = '1;
      cnt_d   = '0;
      busy_d  = 1'b0;
      sreg_en = 1'b1;
    end else if (take) begin
      sreg_d  = hold_word;
      cnt_d   = CNT_W'(sst_char_len(nine, DATA_W));
      busy_d  = 1'b1;
      sreg_en = 1'b1;
    end else if (done) begin
      sreg_d  = '1;
      cnt_d   = '0;
      busy_d  = 1'b0;
      sreg_en = 1'b1;
    end else if (busy && shift_pulse) begin
      sreg_d  = {1'b1, sreg_q[WORD_W-1:1]};
      cnt_d   = cnt_q - CNT_W'(1);
      sreg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      cnt_q  <= '0;
      busy   <= 1'b0;
    end else if (sreg_en) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      busy   <= busy_d;
    end
  end

  assign ser_bit = busy ? sreg_q[0] : 1'b1;

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0 && cnt_q <= CNT_W'(WORD_W)));
  a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run && !shift_pulse) |=> $stable(ser_bit));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int unsigned DATA_W      = sst_pkg::SST_DATA_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sync,
  input  logic              cfg_clk_master,
  input  logic              cfg_rx_single,
  input  logic              cfg_rx_cont,
  input  logic              cfg_port_en,
  input  logic              cfg_tx_en,
  input  logic              cfg_nine_bit,
  input  logic              cfg_clk_pol,
  input  logic              ninth_bit_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_tx_en,
  input  logic              irq_periph_en,
  input  logic              ext_clk,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              shift_empty,
  output logic              buf_empty,
  output logic              tx_irq
);
  logic              active, run;
  logic              shift_pulse;
  logic              take, busy, hold_valid;
  logic [WORD_W-1:0] hold_word;

  assign active = cfg_sync & ~cfg_clk_master & ~cfg_rx_single & ~cfg_rx_cont & cfg_port_en;
  assign run    = active & cfg_tx_en;

  sst_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .pol(cfg_clk_pol), .shift_pulse(shift_pulse)
  );

  sst_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_data(wr_data),
    .ninth_in(ninth_bit_in), .take(take), .hold_valid(hold_valid), .hold_word(hold_word)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .nine(cfg_nine_bit), .shift_pulse(shift_pulse),
    .hold_valid(hold_valid), .hold_word(hold_word), .take(take), .busy(busy), .ser_bit(ser_out)
  );

  assign ser_oe      = active;
  assign shift_empty = ~busy;
  assign buf_empty   = ~hold_valid;
  assign tx_irq      = buf_empty & irq_tx_en & irq_periph_en;

  a_r8_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (shift_empty && buf_empty));
  a_r4_waiting_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && busy && !shift_pulse && run) |=> hold_valid);
  a_r9_irq_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> !hold_valid);
endmodule

// File: tb/sync_slave_tx_test.sv
module sync_slave_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sync = 1, cfg_clk_master = 0, cfg_rx_single = 0, cfg_rx_cont = 0;
  logic cfg_port_en = 1, cfg_tx_en = 1, cfg_nine_bit = 0, cfg_clk_pol = 0;
  logic ninth_bit_in = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic irq_tx_en = 1, irq_periph_en = 1, ext_clk = 0;
  logic ser_out, ser_oe, shift_empty, buf_empty, tx_irq;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sync_slave_tx uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_q[$];
  int  m_word, m_idx, m_len;
  bit  m_busy;
  bit  h0, h1, h2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_busy = 0; m_idx = 0; m_len = 8; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      bit run, pulse, done, take, wr_ok;
      run   = cfg_sync && !cfg_clk_master && !cfg_rx_single && !cfg_rx_cont && cfg_port_en && cfg_tx_en;
      pulse = cfg_clk_pol ? (h1 && !h2) : (!h1 && h2);
      done  = m_busy && pulse && (m_idx == m_len - 1);
      take  = run && m_q.size() > 0 && (!m_busy || done);
      wr_ok = run && wr_en && m_q.size() == 0 && !take;
      if (!run) begin
        m_q.delete(); m_busy = 0;
      end else if (take) begin
        m_word = m_q.pop_front(); m_len = cfg_nine_bit ? 9 : 8; m_idx = 0; m_busy = 1;
      end else if (done) begin
        m_busy = 0;
      end else if (m_busy && pulse) begin
        m_idx++;
      end
      if (wr_ok) m_q.push_back({23'd0, ninth_bit_in, wr_data});
      h2 = h1; h1 = h0; h0 = ext_clk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit act, be;
      act = cfg_sync && !cfg_clk_master && !cfg_rx_single && !cfg_rx_cont && cfg_port_en;
      be  = (m_q.size() == 0);
      chk("R3 ser_out model", ser_out, m_busy ? ((m_word >> m_idx) & 1) : 1);
      chk("R6 shift_empty model", shift_empty, !m_busy);
      chk("R4 buf_empty model", buf_empty, be);
      chk("R9 tx_irq model", tx_irq, be && irq_tx_en && irq_periph_en);
      chk("R1 ser_oe model", ser_oe, act);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // Master: sample on the edge leaving idle level, shift edge returns to idle
  task automatic clock_bits(input int n, output int val);
    val = 0;
    for (int i = 0; i < n; i++) begin
      repeat (8) @(negedge clk);
      val |= int'(ser_out) << i;
      ext_clk = ~cfg_clk_pol;
      repeat (8) @(negedge clk);
      ext_clk = cfg_clk_pol;
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R10 reset ser_out", ser_out, 1);
    chk("R10 reset shift_empty", shift_empty, 1);
    chk("R10 reset buf_empty", buf_empty, 1);

    // single word, falling-edge shift
    @(negedge clk); wr_en = 1; wr_data = 8'hA5;
    @(negedge clk); wr_en = 0;
    chk("R2 buf_empty after write", buf_empty, 0);
    @(negedge clk);
    chk("R2 loaded shift_empty", shift_empty, 0);
    chk("R2 loaded buf_empty", buf_empty, 1);
    chk("R2 bit0 shown", ser_out, 1);
    clock_bits(8, v);
    chk("R3 single word lsb first", v, 8'hA5);
    chk("R6 idle after char", shift_empty, 1);
    chk("R6 idle line level", ser_out, 1);

    // back-to-back, then write to full buffer
    wr(8'h3C);
    wr(8'hC3);
    chk("R4 second word waiting", buf_empty, 0);
    wr(8'h77);
    chk("R7 write to full still waiting", buf_empty, 0);
    clock_bits(16, v);
    chk("R4 two words no gap", v, 16'hC33C);
    chk("R6 empty after pair", shift_empty, 1);
    clock_bits(8, v);
    chk("R7 dropped word never sent", v, 8'hFF);

    // nine-bit mode
    cfg_nine_bit = 1;
    ninth_bit_in = 1;
    wr(8'h12);
    ninth_bit_in = 0;
    clock_bits(9, v);
    chk("R5 ninth bit one", v, 9'h112);
    ninth_bit_in = 1;
    @(negedge clk); wr_en = 1; wr_data = 8'h00;
    @(negedge clk); wr_en = 0; ninth_bit_in = 0;
    clock_bits(9, v);
    chk("R5 ninth bit latched at write", v, 9'h100);
    cfg_nine_bit = 0;

    // rising-edge shift
    cfg_clk_pol = 1; ext_clk = 1;
    repeat (6) @(negedge clk);
    wr(8'h5A);
    clock_bits(8, v);
    chk("R3 rising polarity", v, 8'h5A);
    cfg_clk_pol = 0; ext_clk = 0;
    repeat (6) @(negedge clk);

    // interrupt gating
    irq_periph_en = 0;
    @(negedge clk);
    chk("R9 periph enable off", tx_irq, 0);
    irq_periph_en = 1; irq_tx_en = 0;
    @(negedge clk);
    chk("R9 tx enable off", tx_irq, 0);
    irq_tx_en = 1;
    @(negedge clk);
    chk("R9 both on and empty", tx_irq, 1);

    // disable mid character
    wr(8'hF0);
    @(negedge clk);
    clock_bits(3, v);
    wr(8'h99);
    chk("R9 irq low while full", tx_irq, 0);
    cfg_tx_en = 0;
    @(negedge clk);
    chk("R8 flushed shift", shift_empty, 1);
    chk("R8 flushed buffer", buf_empty, 1);
    wr(8'h44);
    chk("R7 write while disabled", buf_empty, 1);
    cfg_tx_en = 1;
    wr(8'h81);
    clock_bits(8, v);
    chk("R8 clean restart", v, 8'h81);

    // receive configuration and master clock setting
    cfg_rx_cont = 1;
    @(negedge clk);
    chk("R1 receive no drive", ser_oe, 0);
    wr(8'h0F);
    chk("R1 receive write ignored", buf_empty, 1);
    chk("R1 receive no shift", shift_empty, 1);
    cfg_rx_cont = 0; cfg_clk_master = 1;
    @(negedge clk);
    chk("R1 master setting no drive", ser_oe, 0);
    cfg_clk_master = 0;
    @(negedge clk);
    chk("R1 transmit drives", ser_oe, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule